// File: doc/BRIEF.md
# 10b/8b Code Group Decoder with Disparity Checking

The block receives one 10-bit line code group per enabled cycle and registers the recovered byte, a control flag and two error flags, one cycle after the group is accepted. The group is handled as a 6-bit sub-block carrying the five low byte bits and a 4-bit sub-block carrying the three high byte bits. Both polarities of every sub-block decode to the same value. The block keeps its own running disparity, so a sub-block that is valid on its own but arrives with the wrong polarity for the stream is reported.

Which control characters are recognised depends on the two sub-blocks together. A 4-bit sub-block that follows the inverted K.28 6-bit pattern is decoded from its complement. The alternate x.7 patterns are legal only after specific 6-bit values. Word alignment and deserialisation are done upstream. Clock enable and the valid strobe must both be high for a group to be taken.

Top module: `line_dec10b8b`

## Requirements
- R1: Bit mapping: code_in[0..5] carry a,b,c,d,e,i and code_in[6..9] carry f,g,h,j. byte_out[4:0] is the 5-bit value x of the 6-bit sub-block and byte_out[7:5] is the 3-bit value y of the 4-bit sub-block. Every data group D.x.y, in either polarity, decodes to byte x + 32*y with k_out, code_err and disp_err low.
- R2: The 6-bit patterns 001111 and 110000 (a first) decode to x = 28 with k_out high. 001110 decodes to D.28 with k_out low. After 110000 the 4-bit sub-block is read complemented, so 0110, 1010, 0101 and 1001 give y = 1, 2, 5 and 6.
- R3: The 6-bit values 23, 27, 29 and 30 followed by 0111 or 1000 decode with k_out high and y = 7. Any other 4-bit pattern after them gives data.
- R4: The 4-bit patterns 1110, 0001, 0111 and 1000 all give y = 7. 0111 and 1000 after 6-bit values 11, 13, 14, 17, 18 or 20 are data.
- R5: code_err rises for a 6-bit pattern outside the table (including every weight other than 2, 3 or 4), for 4-bit 0000 or 1111, and for 0111 or 1000 after any 6-bit value not listed in R3, R4 or as K.28.
- R6: A sub-block of weight 4 (6-bit) or 3 (4-bit) that arrives while the disparity is positive raises disp_err. So does a sub-block of weight 2 (6-bit) or 1 (4-bit) that arrives while the disparity is negative. In both cases the disparity is then taken from that sub-block.
- R7: rd_pos (1 = positive) goes positive after a positive-weight sub-block and negative after a negative-weight one. A neutral sub-block leaves it unchanged, so a group with five ones leaves it as it was.
- R8: A synchronous reset, whatever ce is, clears byte_out, k_out and both flags, and sets rd_pos to 0 (negative).
- R9: When ce or in_valid is low at a clock edge, every output including rd_pos holds.
- R10: The outputs of a group appear one clock edge after the group is accepted.
- R11: Any single flipped bit in a correctly encoded group raises code_err or disp_err, either on that group or on the next group, provided the next group has a non-neutral 6-bit sub-block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable |
| in_valid | input | 1 | Code group present on code_in |
| code_in | input | 10 | Code group, a in bit 0 through j in bit 9 |
| byte_out | output | 8 | Decoded byte |
| k_out | output | 1 | Control character decoded |
| code_err | output | 1 | Group not in the code tables |
| disp_err | output | 1 | Sub-block polarity contradicts running disparity |
| rd_pos | output | 1 | Running disparity, 1 = positive |

## Verification
A behavioural encoder in the bench feeds all 256 data bytes through the decoder twice, and then all twelve control characters. The continuous stream makes every byte appear in both polarities, and shows whether the alternate x.7 choice and the K.28 complement rule decode to the right value. Hand-written groups cover the inverted K.28 sub-blocks, a repeated positive group that must raise disp_err and then resynchronise, and table misses that must raise code_err. Every bit of a range of encoded groups is flipped in turn to check that each single-bit error is caught within two groups. The hold behaviour is tested with junk codes presented while ce is low and while in_valid is low.

// File: rtl/ld_pkg.sv
`timescale 1ns/1ps
package ld_pkg;
    localparam int SIX_W  = 6;
    localparam int FOUR_W = 4;
    localparam int CODE_W = SIX_W + FOUR_W;
    localparam int LO_W   = 5;
    localparam int HI_W   = 3;
    localparam int BYTE_W = LO_W + HI_W;

    typedef enum logic [1:0] {
        POL_NEUT = 2'd0,
        POL_POS  = 2'd1,
        POL_NEG  = 2'd2,
        POL_BAD  = 2'd3
    } pol_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              ctrl;
        logic              code_err;
        logic              disp_err;
        logic              rd_pos;
    } dec_state_t;
endpackage

// File: rtl/ld_polarity.sv
`timescale 1ns/1ps
// Classifies a sub-block by its weight: balanced, one heavy, one light, or illegal.
module ld_polarity
    import ld_pkg::*;
#(
    parameter int W = 6
) (
    input  logic [W-1:0] pat,
    output pol_e         pol
);
    localparam int CW = $clog2(W + 1);
    localparam int HALF = W / 2;

    logic [CW-1:0] ones;

    always_comb begin
        ones = '0;
        for (int n = 0; n < W; n++) begin
            ones = ones + CW'(pat[n]);
        end
        if (ones == CW'(HALF))          pol = POL_NEUT;
        else if (ones == CW'(HALF + 1)) pol = POL_POS;
        else if (ones == CW'(HALF - 1)) pol = POL_NEG;
        else                            pol = POL_BAD;
    end
endmodule

// File: rtl/ld_sub6_dec.sv
`timescale 1ns/1ps
// 6-bit sub-block lookup; pattern given with a in the MSB.
module ld_sub6_dec
    import ld_pkg::*;
(
    input  logic [SIX_W-1:0] pat,
    output logic [LO_W-1:0]  val,
    output logic             is_k28,
    output logic             k_cap,
    output logic             alt_ok,
    output logic             ok
);
    always_comb begin
        val    = '0;
        is_k28 = 1'b0;
        k_cap  = 1'b0;
        alt_ok = 1'b0;
        ok     = 1'b1;
        unique case (pat)
            6'b100111, 6'b011000: val = 5'd0;
            6'b011101, 6'b100010: val = 5'd1;
            6'b101101, 6'b010010: val = 5'd2;
            6'b110001:            val = 5'd3;
            6'b110101, 6'b001010: val = 5'd4;
            6'b101001:            val = 5'd5;
            6'b011001:            val = 5'd6;
            6'b111000, 6'b000111: val = 5'd7;
            6'b111001, 6'b000110: val = 5'd8;
            6'b100101:            val = 5'd9;
            6'b010101:            val = 5'd10;
            6'b110100: begin      val = 5'd11; alt_ok = 1'b1; end
            6'b001101:            val = 5'd12;
            6'b101100: begin      val = 5'd13; alt_ok = 1'b1; end
            6'b011100: begin      val = 5'd14; alt_ok = 1'b1; end
            6'b010111, 6'b101000: val = 5'd15;
            6'b011011, 6'b100100: val = 5'd16;
            6'b100011: begin      val = 5'd17; alt_ok = 1'b1; end
            6'b010011: begin      val = 5'd18; alt_ok = 1'b1; end
            6'b110010:            val = 5'd19;
            6'b001011: begin      val = 5'd20; alt_ok = 1'b1; end
            6'b101010:            val = 5'd21;
            6'b011010:            val = 5'd22;
            6'b111010, 6'b000101: begin val = 5'd23; k_cap = 1'b1; end
            6'b110011, 6'b001100: val = 5'd24;
            6'b100110:            val = 5'd25;
            6'b010110:            val = 5'd26;
            6'b110110, 6'b001001: begin val = 5'd27; k_cap = 1'b1; end
            6'b001110:            val = 5'd28;
            6'b001111, 6'b110000: begin val = 5'd28; is_k28 = 1'b1; end
            6'b101110, 6'b010001: begin val = 5'd29; k_cap = 1'b1; end
            6'b011110, 6'b100001: begin val = 5'd30; k_cap = 1'b1; end
            6'b101011, 6'b010100: val = 5'd31;
            default:              ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/ld_sub4_dec.sv
`timescale 1ns/1ps
// 4-bit sub-block lookup; pattern given with f in the MSB. flip reads it complemented.
module ld_sub4_dec
    import ld_pkg::*;
(
    input  logic [FOUR_W-1:0] pat,
    input  logic              flip,
    output logic [HI_W-1:0]   val,
    output logic              is_alt,
    output logic              ok
);
    logic [FOUR_W-1:0] eff;

    always_comb begin
        eff    = flip ? ~pat : pat;
        val    = '0;
        is_alt = 1'b0;
        ok     = 1'b1;
        unique case (eff)
            4'b1011, 4'b0100: val = 3'd0;
            4'b1001:          val = 3'd1;
            4'b0101:          val = 3'd2;
            4'b1100, 4'b0011: val = 3'd3;
            4'b1101, 4'b0010: val = 3'd4;
            4'b1010:          val = 3'd5;
            4'b0110:          val = 3'd6;
            4'b1110, 4'b0001: val = 3'd7;
            4'b0111, 4'b1000: begin val = 3'd7; is_alt = 1'b1; end
            default:          ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/ld_disp.sv
`timescale 1ns/1ps
// Checks both sub-block polarities against the running disparity and resynchronises it.
module ld_disp
    import ld_pkg::*;
(
    input  logic rd_in,
    input  pol_e pol6,
    input  pol_e pol4,
    output logic mismatch,
    output logic rd_out
);
    logic rd_mid;
    logic bad6;
    logic bad4;

    always_comb begin
        bad6   = 1'b0;
        rd_mid = rd_in;
        case (pol6)
            POL_POS: begin bad6 = rd_in;  rd_mid = 1'b1; end
            POL_NEG: begin bad6 = !rd_in; rd_mid = 1'b0; end
            default: ;
        endcase
        bad4   = 1'b0;
        rd_out = rd_mid;
        case (pol4)
            POL_POS: begin bad4 = rd_mid;  rd_out = 1'b1; end
            POL_NEG: begin bad4 = !rd_mid; rd_out = 1'b0; end
            default: ;
        endcase
        mismatch = bad6 | bad4;
    end
endmodule

// File: rtl/line_dec10b8b.sv
`timescale 1ns/1ps
module line_dec10b8b
    import ld_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              in_valid,
    input  logic [CODE_W-1:0] code_in,
    output logic [BYTE_W-1:0] byte_out,
    output logic              k_out,
    output logic              code_err,
    output logic              disp_err,
    output logic              rd_pos
);
    dec_state_t st_q;
    dec_state_t st_d;

    logic [SIX_W-1:0]  six_pat;
    logic [FOUR_W-1:0] four_pat;

    // Reorder so that the first transmitted bit of each sub-block sits in the MSB.
    always_comb begin
        for (int n = 0; n < SIX_W; n++)  six_pat[SIX_W-1-n]   = code_in[n];
        for (int m = 0; m < FOUR_W; m++) four_pat[FOUR_W-1-m] = code_in[SIX_W+m];
    end

    logic [LO_W-1:0] x_val;
    logic            six_k28, six_kcap, six_altok, six_ok;
    logic [HI_W-1:0] y_val;
    logic            four_alt, four_ok;
    logic            four_flip;
    pol_e            pol6, pol4;
    logic            rd_mis, rd_next;

    assign four_flip = (six_pat == 6'b110000);

    ld_sub6_dec u_six (
        .pat    (six_pat),
        .val    (x_val),
        .is_k28 (six_k28),
        .k_cap  (six_kcap),
        .alt_ok (six_altok),
        .ok     (six_ok)
    );

    ld_sub4_dec u_four (
        .pat    (four_pat),
        .flip   (four_flip),
        .val    (y_val),
        .is_alt (four_alt),
        .ok     (four_ok)
    );

    ld_polarity #(.W(SIX_W)) u_pol6 (
        .pat (six_pat),
        .pol (pol6)
    );

    ld_polarity #(.W(FOUR_W)) u_pol4 (
        .pat (four_pat),
        .pol (pol4)
    );

    ld_disp u_disp (
        .rd_in    (st_q.rd_pos),
        .pol6     (pol6),
        .pol4     (pol4),
        .mismatch (rd_mis),
        .rd_out   (rd_next)
    );

    logic alt_legal;
    logic is_ctrl;
    logic bad_group;

    always_comb begin
        alt_legal = six_altok | six_kcap | six_k28;
        bad_group = !six_ok | !four_ok | (four_alt & !alt_legal);
        is_ctrl   = six_ok & four_ok & (six_k28 | (six_kcap & four_alt));

        st_d = st_q;
        if (ce && in_valid) begin
            st_d.data     = {y_val, x_val};
            st_d.ctrl     = is_ctrl;
            st_d.code_err = bad_group;
            st_d.disp_err = rd_mis;
            st_d.rd_pos   = rd_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign byte_out = st_q.data;
    assign k_out    = st_q.ctrl;
    assign code_err = st_q.code_err;
    assign disp_err = st_q.disp_err;
    assign rd_pos   = st_q.rd_pos;
endmodule

// File: rtl/line_dec10b8b_chk.sv
`timescale 1ns/1ps
module line_dec10b8b_chk (
    input logic       clk,
    input logic       rst,
    input logic       ce,
    input logic       in_valid,
    input logic [9:0] code_in,
    input logic [7:0] byte_out,
    input logic       k_out,
    input logic       code_err,
    input logic       disp_err,
    input logic       rd_pos
);
    assert_reset_state_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rd_pos && !k_out && !code_err && !disp_err && byte_out == 8'h00));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ce && in_valid)) |->
            ($stable(byte_out) && $stable(k_out) && $stable(code_err)
             && $stable(disp_err) && $stable(rd_pos)));

    assert_bad_four_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ce && in_valid)
         && ($past(code_in[9:6]) == 4'b0000 || $past(code_in[9:6]) == 4'b1111)) |-> code_err);

    assert_balanced_keeps_rd_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ce && in_valid) && $countones($past(code_in)) == 5
         && !disp_err && !code_err) |-> (rd_pos == $past(rd_pos)));

    assert_k_low_value_R2: assert property (@(posedge clk) disable iff (rst)
        k_out |-> (byte_out[4:0] inside {5'd23, 5'd27, 5'd28, 5'd29, 5'd30}));

    assert_k_high_seven_R3: assert property (@(posedge clk) disable iff (rst)
        (k_out && byte_out[4:0] != 5'd28) |-> (byte_out[7:5] == 3'd7));
endmodule

bind line_dec10b8b line_dec10b8b_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ce       (ce),
    .in_valid (in_valid),
    .code_in  (code_in),
    .byte_out (byte_out),
    .k_out    (k_out),
    .code_err (code_err),
    .disp_err (disp_err),
    .rd_pos   (rd_pos)
);

// File: tb/sim_line_dec10b8b.sv
`timescale 1ns/1ps
module sim_line_dec10b8b;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce = 1'b0;
    logic       in_valid = 1'b0;
    logic [9:0] code_in = '0;
    logic [7:0] byte_out;
    logic       k_out, code_err, disp_err, rd_pos;

    line_dec10b8b u0 (
        .clk(clk), .rst(rst), .ce(ce), .in_valid(in_valid), .code_in(code_in),
        .byte_out(byte_out), .k_out(k_out), .code_err(code_err),
        .disp_err(disp_err), .rd_pos(rd_pos)
    );

    always #2 clk = ~clk;

    localparam logic [1:0] KD_EXACT = 2'd0, KD_CERR = 2'd1, KD_EGRP = 2'd2, KD_EFOL = 2'd3;

    typedef struct packed {
        logic [7:0] b;
        logic       k;
        logic       cerr;
        logic       derr;
        logic       rd;
        logic [1:0] kind;
        logic [7:0] req;
    } exp_t;

    exp_t q[$];
    exp_t last_e;
    int   total = 0;
    int   bad = 0;
    logic enc_rd = 1'b0;
    logic err_seen = 1'b0;
    bit   finished = 1'b0;

    task automatic check(input bit ok, input int req, input string what,
                         input logic [11:0] act, input logic [11:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic logic [9:0] port_of(input logic [5:0] six, input logic [3:0] four);
        logic [9:0] p;
        for (int n = 0; n < 6; n++) p[n] = six[5-n];
        for (int m = 0; m < 4; m++) p[6+m] = four[3-m];
        return p;
    endfunction

    // Forms chosen when the incoming disparity is negative.
    function automatic logic [5:0] six_neg(input logic [4:0] x);
        case (x)
            5'd0: return 6'b100111;  5'd1: return 6'b011101;  5'd2: return 6'b101101;
            5'd3: return 6'b110001;  5'd4: return 6'b110101;  5'd5: return 6'b101001;
            5'd6: return 6'b011001;  5'd7: return 6'b111000;  5'd8: return 6'b111001;
            5'd9: return 6'b100101;  5'd10: return 6'b010101; 5'd11: return 6'b110100;
            5'd12: return 6'b001101; 5'd13: return 6'b101100; 5'd14: return 6'b011100;
            5'd15: return 6'b010111; 5'd16: return 6'b011011; 5'd17: return 6'b100011;
            5'd18: return 6'b010011; 5'd19: return 6'b110010; 5'd20: return 6'b001011;
            5'd21: return 6'b101010; 5'd22: return 6'b011010; 5'd23: return 6'b111010;
            5'd24: return 6'b110011; 5'd25: return 6'b100110; 5'd26: return 6'b010110;
            5'd27: return 6'b110110; 5'd28: return 6'b001110; 5'd29: return 6'b101110;
            5'd30: return 6'b011110; default: return 6'b101011;
        endcase
    endfunction

    function automatic logic [3:0] four_neg(input logic [2:0] y);
        case (y)
            3'd0: return 4'b1011; 3'd1: return 4'b1001; 3'd2: return 4'b0101;
            3'd3: return 4'b1100; 3'd4: return 4'b1101; 3'd5: return 4'b1010;
            3'd6: return 4'b0110; default: return 4'b1110;
        endcase
    endfunction

    // Behavioural encoder; advances enc_rd.
    task automatic enc(input logic [7:0] b, input logic k, output logic [9:0] port);
        logic [4:0] x;
        logic [2:0] y;
        logic [5:0] six;
        logic [3:0] four;
        logic       rd6;
        logic       k28;
        logic       use_alt;
        x   = b[4:0];
        y   = b[7:5];
        k28 = k && (x == 5'd28);
        six = k28 ? 6'b001111 : six_neg(x);
        if (enc_rd && ($countones(six) != 3 || (x == 5'd7 && !k))) six = ~six;
        rd6 = ($countones(six) == 4) ? 1'b1 : ($countones(six) == 2) ? 1'b0 : enc_rd;
        use_alt = (y == 3'd7) && (k || (!rd6 && (x == 17 || x == 18 || x == 20))
                                    || (rd6 && (x == 11 || x == 13 || x == 14)));
        four = use_alt ? 4'b0111 : four_neg(y);
        if (rd6 && ($countones(four) != 2 || y == 3'd3)) four = ~four;
        if (k28 && !rd6 && (y == 1 || y == 2 || y == 5 || y == 6)) four = ~four;
        enc_rd = ($countones(four) == 3) ? 1'b1 : ($countones(four) == 1) ? 1'b0 : rd6;
        port = port_of(six, four);
    endtask

    task automatic drive(input logic [9:0] c, input exp_t e);
        @(negedge clk);
        ce = 1'b1;
        in_valid = 1'b1;
        code_in = c;
        q.push_back(e);
    endtask

    task automatic send_enc(input logic [7:0] b, input logic k, input int req);
        logic [9:0] c;
        exp_t e;
        enc(b, k, c);
        e = '{b: b, k: k, cerr: 1'b0, derr: 1'b0, rd: enc_rd, kind: KD_EXACT, req: 8'(req)};
        drive(c, e);
    endtask

    task automatic send_raw(input logic [9:0] c, input logic [7:0] b, input logic k,
                            input logic derr, input logic rd, input int req);
        exp_t e;
        e = '{b: b, k: k, cerr: 1'b0, derr: derr, rd: rd, kind: KD_EXACT, req: 8'(req)};
        drive(c, e);
    endtask

    task automatic send_kind(input logic [9:0] c, input logic [1:0] kind, input int req);
        exp_t e;
        e = '{b: 8'h00, k: 1'b0, cerr: 1'b0, derr: 1'b0, rd: 1'b0, kind: kind, req: 8'(req)};
        drive(c, e);
    endtask

    task automatic do_reset(input bit chk);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        enc_rd = 1'b0;
        if (chk) begin
            // R8: cleared outputs, negative disparity
            check({byte_out, k_out, code_err, disp_err, rd_pos} == 12'h000, 8, "reset state",
                  {byte_out, k_out, code_err, disp_err, rd_pos}, 12'h000);
        end
    endtask

    // Monitor: one result per accepted group, one edge later (R10).
    initial begin
        forever begin
            bit   fire;
            exp_t e;
            @(posedge clk);
            fire = !rst && ce && in_valid;
            #1;
            if (fire) begin
                if (q.size() == 0) begin
                    check(1'b0, 10, "unexpected result", 12'h0, 12'h0);
                end else begin
                    e = q.pop_front();
                    case (e.kind)
                        KD_EXACT: begin
                            check({byte_out, k_out, code_err, disp_err, rd_pos}
                                  == {e.b, e.k, e.cerr, e.derr, e.rd}, int'(e.req), "decode",
                                  {byte_out, k_out, code_err, disp_err, rd_pos},
                                  {e.b, e.k, e.cerr, e.derr, e.rd});
                            last_e = e;
                        end
                        KD_CERR: check(code_err == 1'b1, int'(e.req), "code_err",
                                       12'(code_err), 12'h1);
                        KD_EGRP: err_seen = code_err | disp_err;
                        default: check(err_seen | code_err | disp_err, int'(e.req),
                                       "single-bit error flagged",
                                       12'({err_seen, code_err, disp_err}), 12'h1);
                    endcase
                end
            end
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [9:0] c;
        do_reset(1'b1);

        // R7: D.0.1 negative form leaves disparity positive
        send_raw(port_of(6'b100111, 4'b1001), 8'h20, 1'b0, 1'b0, 1'b1, 7);
        // R6: same group again contradicts positive disparity
        send_raw(port_of(6'b100111, 4'b1001), 8'h20, 1'b0, 1'b1, 1'b1, 6);
        enc_rd = 1'b1;
        // R6: stream resumes cleanly after resynchronisation
        for (int i = 0; i < 6; i++) send_enc(8'(i * 41 + 3), 1'b0, 6);

        // R9: junk while ce low, then while in_valid low
        @(negedge clk);
        ce = 1'b0; in_valid = 1'b1; code_in = port_of(6'b110000, 4'b1111);
        @(negedge clk);
        ce = 1'b1; in_valid = 1'b0; code_in = port_of(6'b001111, 4'b0000);
        @(negedge clk);
        check({byte_out, k_out, code_err, disp_err, rd_pos}
              == {last_e.b, last_e.k, last_e.cerr, last_e.derr, last_e.rd}, 9, "hold",
              {byte_out, k_out, code_err, disp_err, rd_pos},
              {last_e.b, last_e.k, last_e.cerr, last_e.derr, last_e.rd});

        // R2: both K.28 forms and the complemented 4-bit read
        do_reset(1'b0);
        send_raw(port_of(6'b100111, 4'b1001), 8'h20, 1'b0, 1'b0, 1'b1, 7);
        send_raw(port_of(6'b110000, 4'b0110), 8'h3C, 1'b1, 1'b0, 1'b0, 2);
        send_raw(port_of(6'b001111, 4'b1001), 8'h3C, 1'b1, 1'b0, 1'b1, 2);
        send_raw(port_of(6'b110000, 4'b0101), 8'hBC, 1'b1, 1'b0, 1'b0, 2);
        // R2: D.28 pattern stays data
        send_raw(port_of(6'b001110, 4'b1011), 8'h1C, 1'b0, 1'b0, 1'b1, 2);
        enc_rd = 1'b1;

        // R1, R4, R7: all data bytes, twice, in a continuous stream
        for (int p = 0; p < 2; p++)
            for (int b = 0; b < 256; b++) send_enc(8'(b), 1'b0, 1);

        // R2, R3: every control character in both disparities
        for (int p = 0; p < 2; p++) begin
            for (int y = 0; y < 8; y++) send_enc(8'(y * 32 + 28), 1'b1, 2);
            send_enc(8'hF7, 1'b1, 3);
            send_enc(8'hFB, 1'b1, 3);
            send_enc(8'hFD, 1'b1, 3);
            send_enc(8'hFE, 1'b1, 3);
            send_enc(8'h05, 1'b0, 3);
        end
        // R4: alternate forms as data, primary after a control-capable value
        send_enc(8'hF1, 1'b0, 4);
        send_enc(8'hEB, 1'b0, 4);
        send_enc(8'hF7, 1'b0, 4);

        // R5: table misses
        do_reset(1'b0);
        send_kind(port_of(6'b111100, 4'b1011), KD_CERR, 5);
        send_kind(port_of(6'b100111, 4'b0111), KD_CERR, 5);
        send_kind(port_of(6'b110001, 4'b1111), KD_CERR, 5);
        send_kind(port_of(6'b000000, 4'b1011), KD_CERR, 5);
        send_kind(port_of(6'b110001, 4'b0000), KD_CERR, 5);

        // R11: single-bit errors
        for (int s = 0; s < 24; s++) begin
            for (int bit_i = 0; bit_i < 10; bit_i++) begin
                do_reset(1'b0);
                send_enc(8'(s * 11), 1'b0, 1);
                enc(8'(s * 37 + 5), 1'b0, c);
                c[bit_i] = ~c[bit_i];
                send_kind(c, KD_EGRP, 11);
                enc(8'h00, 1'b0, c);
                send_kind(c, KD_EFOL, 11);
            end
        end

        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(q.size() == 0, 10, "all results seen", 12'(q.size()), 12'h0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule